// File: doc/BRIEF.md
# Three-Digit Decimal Adder-Subtractor

This block adds or subtracts two unsigned three-digit decimal operands, each given as packed binary-coded decimal with one 4-bit code per digit. Every digit stage is a small binary adder followed by a decimal fix-up, and the stages are chained by ripple carry. A single mode input picks the operation. To subtract, the second operand is first replaced by its nines complement and added to the first operand. If that first pass produces a decimal carry out, the difference is positive, and an end-around carry of one is added in a second pass. If it produces no carry out, the difference is negative, and its magnitude is the nines complement of the first-pass sum.

The results are three decimal digits, a thousands flag for sums of 1000 or more, a sign flag for negative differences, and an error flag. The error flag rises when any input digit holds a code that is not decimal. The arithmetic itself is combinational. All outputs are registered on the rising clock edge and cleared by a synchronous active-high reset, so a result appears one cycle after its operands are sampled.

Top module: `bcd_addsub3`

## Requirements
- R1: Digit layout: bits [3:0] hold units, [7:4] tens and [11:8] hundreds, in both operands and the result. `op_sub`=0 selects addition and `op_sub`=1 selects subtraction of `b_bcd` from `a_bcd`.
- R2: In add mode with legal operands, `res_bcd` is (A+B) mod 1000. `thousands` is 1 exactly when A+B is 1000 or more.
- R3: In subtract mode with A greater than B, `res_bcd` is A-B and `sign_neg` is 0.
- R4: In subtract mode with A less than B, `res_bcd` is B-A (the magnitude) and `sign_neg` is 1.
- R5: Subtracting equal operands gives 000 with `sign_neg` 0 (no negative zero).
- R6: `thousands` is always 0 in subtract mode. `sign_neg` is always 0 in add mode. The two flags are never high together.
- R7: `code_err` is 1 exactly when any digit of either operand holds a code from 1010 to 1111, and 0 otherwise.
- R8: While `code_err` is 1, `res_bcd`, `sign_neg` and `thousands` are all 0.
- R9: Every result digit is a legal decimal code (0 to 9).
- R10: Outputs show the result for the inputs sampled at the previous rising edge. With `rst` high at an edge, all outputs become 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| a_bcd | input | 12 | First operand, three packed decimal digits |
| b_bcd | input | 12 | Second operand, three packed decimal digits |
| res_bcd | output | 12 | Result digits (sum modulo 1000, or difference magnitude) |
| thousands | output | 1 | Sum reached 1000 or more (add mode only) |
| sign_neg | output | 1 | Difference is negative (subtract mode only) |
| code_err | output | 1 | An operand digit holds a non-decimal code |

## Verification
The assertions that check arithmetic results compare each registered output with the inputs held across the previous clock edge. They therefore assume the operands and the mode stay stable from one sampling edge until the following one. The assertions also ignore the edge that comes straight after a reset cycle, because the registers hold zeros there. The stimulus changes inputs only on falling edges and holds each vector for a full cycle. Only the error directed tests drive non-decimal digit codes, so every other vector stays inside the legal 0 to 999 range.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  function automatic logic digit_illegal(input bcd_digit_t d);
    return d > 4'd9;
  endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  bcd_digit_t x,
  input  bcd_digit_t y,
  input  logic       ci,
  output bcd_digit_t s,
  output logic       co
);
  logic [DIGIT_W:0] raw;
  logic             fix;

  always_comb begin
    raw = {1'b0, x} + {1'b0, y} + {{DIGIT_W{1'b0}}, ci};
    // Binary carry or a value above nine both need the +6 skip.
    fix = (raw > 5'd9);
    s   = fix ? (raw[DIGIT_W-1:0] + 4'd6) : raw[DIGIT_W-1:0];
    co  = fix;
  end
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int W = NDIG * DIGIT_W
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign dout[g*DIGIT_W +: DIGIT_W] = en ? (4'd9 - din[g*DIGIT_W +: DIGIT_W])
                                           : din[g*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
  import bcd_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int W = NDIG * DIGIT_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [NDIG:0] cy;
  assign cy[0] = ci;

  for (genvar g = 0; g < NDIG; g++) begin : g_stage
    bcd_digit_add u_dig (
      .x  (x[g*DIGIT_W +: DIGIT_W]),
      .y  (y[g*DIGIT_W +: DIGIT_W]),
      .ci (cy[g]),
      .s  (s[g*DIGIT_W +: DIGIT_W]),
      .co (cy[g+1])
    );
  end

  assign co = cy[NDIG];
endmodule

// File: rtl/bcd_addsub3.sv
module bcd_addsub3
  import bcd_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int W = NDIG * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_sub,
  input  logic [W-1:0] a_bcd,
  input  logic [W-1:0] b_bcd,
  output logic [W-1:0] res_bcd,
  output logic         thousands,
  output logic         sign_neg,
  output logic         code_err
);
  localparam logic [W-1:0] ALL_NINES = {NDIG{4'd9}};

  logic [W-1:0] b_eff, sum1, sum2, sum1_c;
  logic         c1, c2, eac, neg_path;
  logic [2*NDIG-1:0] bad;

  // First pass: A plus B, or A plus the nines complement of B.
  bcd_nines #(.NDIG(NDIG)) u_bcomp (.en(op_sub), .din(b_bcd), .dout(b_eff));
  bcd_ripple #(.NDIG(NDIG)) u_pass1 (.x(a_bcd), .y(b_eff), .ci(1'b0), .s(sum1), .co(c1));

  // Second pass: end-around carry for a positive difference.
  assign eac = op_sub & c1;
  bcd_ripple #(.NDIG(NDIG)) u_pass2 (.x(sum1), .y('0), .ci(eac), .s(sum2), .co(c2));

  // Negative difference: the magnitude is the complement of the first pass.
  bcd_nines #(.NDIG(NDIG)) u_mcomp (.en(1'b1), .din(sum1), .dout(sum1_c));
  assign neg_path = op_sub & ~c1;

  for (genvar g = 0; g < NDIG; g++) begin : g_chk
    assign bad[2*g]   = digit_illegal(a_bcd[g*DIGIT_W +: DIGIT_W]);
    assign bad[2*g+1] = digit_illegal(b_bcd[g*DIGIT_W +: DIGIT_W]);
  end

  logic         err_n;
  logic [W-1:0] res_n;
  logic         th_n, sg_n;

  always_comb begin
    err_n = |bad;
    res_n = neg_path ? sum1_c : sum2;
    th_n  = ~op_sub & c1;
    // A first-pass sum of all nines is a zero difference, not a negative one.
    sg_n  = neg_path & (sum1 != ALL_NINES);
    if (err_n) begin
      res_n = '0;
      th_n  = 1'b0;
      sg_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_bcd   <= '0;
      thousands <= 1'b0;
      sign_neg  <= 1'b0;
      code_err  <= 1'b0;
    end else begin
      res_bcd   <= res_n;
      thousands <= th_n;
      sign_neg  <= sg_n;
      code_err  <= err_n;
    end
  end

  logic unused_c2;
  assign unused_c2 = c2;
endmodule

// File: rtl/bcd_addsub3_chk.sv
module bcd_addsub3_chk
  import bcd_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int W = NDIG * DIGIT_W
) (
  input logic         clk,
  input logic         rst,
  input logic         op_sub,
  input logic [W-1:0] a_bcd,
  input logic [W-1:0] b_bcd,
  input logic [W-1:0] res_bcd,
  input logic         thousands,
  input logic         sign_neg,
  input logic         code_err
);
  logic in_bad;
  always_comb begin
    in_bad = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      if (a_bcd[i*DIGIT_W +: DIGIT_W] > 4'd9 || b_bcd[i*DIGIT_W +: DIGIT_W] > 4'd9)
        in_bad = 1'b1;
    end
  end

  // R6
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(thousands && sign_neg));
  a_r6_no_sign_in_add: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(op_sub) |-> !sign_neg);
  a_r6_no_th_in_sub: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(op_sub) |-> !thousands);
  // R7
  a_r7_err_flag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (code_err == $past(in_bad)));
  // R8
  a_r8_err_zero: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (res_bcd == '0 && !sign_neg && !thousands));
  // R5
  a_r5_equal_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(op_sub) && $past(a_bcd == b_bcd) && !$past(in_bad)
      |-> (res_bcd == '0 && !sign_neg));
  // R10
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (res_bcd == '0 && !thousands && !sign_neg && !code_err));

  // R9
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    a_r9_digit_legal: assert property (@(posedge clk) disable iff (rst)
      res_bcd[g*DIGIT_W +: DIGIT_W] <= 4'd9);
  end
endmodule

bind bcd_addsub3 bcd_addsub3_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst(rst), .op_sub(op_sub), .a_bcd(a_bcd), .b_bcd(b_bcd),
  .res_bcd(res_bcd), .thousands(thousands), .sign_neg(sign_neg), .code_err(code_err)
);

// File: tb/sim_bcd_addsub3.sv
module sim_bcd_addsub3;
  localparam int PERIOD = 10;
  localparam int NV = 10;

  // Table: mode, A, B, expected result, thousands, sign.
  localparam logic        T_OP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                        1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [11:0] T_A  [NV] = '{12'h767, 12'h767, 12'h000, 12'h000, 12'h999,
                                        12'h999, 12'h005, 12'h732, 12'h177, 12'h177};
  localparam logic [11:0] T_B  [NV] = '{12'h732, 12'h732, 12'h177, 12'h177, 12'h005,
                                        12'h005, 12'h999, 12'h767, 12'h000, 12'h000};
  localparam logic [11:0] T_R  [NV] = '{12'h499, 12'h035, 12'h177, 12'h177, 12'h004,
                                        12'h994, 12'h994, 12'h035, 12'h177, 12'h177};
  localparam logic        T_TH [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
                                        1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic        T_SG [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                                        1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_sub = 1'b0;
  logic [11:0] a_bcd = '0, b_bcd = '0, res_bcd;
  logic thousands, sign_neg, code_err;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bcd_addsub3 u0 (.clk(clk), .rst(rst), .op_sub(op_sub), .a_bcd(a_bcd), .b_bcd(b_bcd),
                  .res_bcd(res_bcd), .thousands(thousands), .sign_neg(sign_neg),
                  .code_err(code_err));

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input logic [11:0] r, input logic th,
                       input logic sg, input logic er);
    n_chk++;
    if (res_bcd !== r || thousands !== th || sign_neg !== sg || code_err !== er) begin
      n_bad++;
      $display("FAIL %s: got res=%h th=%b sg=%b err=%b, expected res=%h th=%b sg=%b err=%b",
               req, res_bcd, thousands, sign_neg, code_err, r, th, sg, er);
    end
  endtask

  task automatic apply(input logic op, input logic [11:0] a, input logic [11:0] b);
    @(negedge clk);
    op_sub = op; a_bcd = a; b_bcd = b;
    @(negedge clk);
  endtask

  task automatic model_check(input int a, input int b, input logic op);
    int d;
    apply(op, to_bcd(a), to_bcd(b));
    if (!op) check("R2", to_bcd((a + b) % 1000), (a + b) >= 1000, 1'b0, 1'b0);
    else begin
      d = a - b;
      if (d > 0) check("R3", to_bcd(d), 1'b0, 1'b0, 1'b0);
      else if (d < 0) check("R4", to_bcd(-d), 1'b0, 1'b1, 1'b0);
      else check("R5", 12'h000, 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset clears outputs even with live inputs.
    op_sub = 1'b0; a_bcd = 12'h999; b_bcd = 12'h999;
    repeat (3) @(negedge clk);
    check("R10 reset", 12'h000, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1/R2/R3/R4 table walk.
    for (int i = 0; i < NV; i++) begin
      apply(T_OP[i], T_A[i], T_B[i]);
      check(T_OP[i] ? (T_SG[i] ? "R4 table" : "R3 table") : "R2 table",
            T_R[i], T_TH[i], T_SG[i], 1'b0);
    end

    // R2 corner: largest sum.
    apply(1'b0, 12'h999, 12'h999); check("R2 max sum", 12'h998, 1'b1, 1'b0, 1'b0);
    apply(1'b0, 12'h500, 12'h500); check("R2 exact 1000", 12'h000, 1'b1, 1'b0, 1'b0);
    // R5 equal operands.
    apply(1'b1, 12'h000, 12'h000); check("R5 zero", 12'h000, 1'b0, 1'b0, 1'b0);
    apply(1'b1, 12'h999, 12'h999); check("R5 nines", 12'h000, 1'b0, 1'b0, 1'b0);
    apply(1'b1, 12'h000, 12'h999); check("R4 extreme", 12'h999, 1'b0, 1'b1, 1'b0);
    // R7/R8 illegal codes in each operand and position.
    apply(1'b0, 12'h76A, 12'h732); check("R7 a units", 12'h000, 1'b0, 1'b0, 1'b1);
    apply(1'b1, 12'h005, 12'hF99); check("R8 b hundreds", 12'h000, 1'b0, 1'b0, 1'b1);
    apply(1'b1, 12'h0B0, 12'h999); check("R8 a tens sub", 12'h000, 1'b0, 1'b0, 1'b1);
    apply(1'b0, 12'h999, 12'h9C9); check("R7 b tens", 12'h000, 1'b0, 1'b0, 1'b1);
    // R7 clears when legal again, R6 flags per mode.
    apply(1'b1, 12'h100, 12'h001); check("R6 sub no thousands", 12'h099, 1'b0, 1'b0, 1'b0);
    // R10 one-cycle latency: result changes only after the edge.
    @(negedge clk); op_sub = 1'b0; a_bcd = 12'h123; b_bcd = 12'h456;
    #1 check("R10 hold", 12'h099, 1'b0, 1'b0, 1'b0);
    @(negedge clk); check("R10 update", 12'h579, 1'b0, 1'b0, 1'b0);
    // R10 mid-run reset.
    @(negedge clk); rst = 1'b1; @(negedge clk);
    check("R10 mid reset", 12'h000, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1 sweep against the decimal model.
    for (int a = 0; a < 1000; a += 37)
      for (int b = 0; b < 1000; b += 53) begin
        model_check(a, b, 1'b0);
        model_check(a, b, 1'b1);
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule